// File: doc/BRIEF.md
# Audio Serial Port Clocking Unit

This block is the digital side of an audio codec's serial port. In clock-master mode it runs everything from one master clock. It derives a bit clock at half the master clock rate and two frame clocks, one for the capture (ADC) path and one for the playback (DAC) path. It shifts ADC sample words out serially and collects DAC sample words arriving serially. In clock-slave mode it drives none of the three port clocks. Instead it re-times the externally supplied bit and frame clocks into the master clock domain and moves data in step with them.

Two registers set its behaviour through a single-cycle write port. One holds the master/slave choice. The other holds a normal/12 MHz-USB base select, a base oversampling select and a 4-bit rate code. The rate code picks a pair of capture and playback frame rates, which may differ. New settings are first held pending. They take effect only when both frame counters wrap together, or at once when the port clocks are idle, so no shortened clock pulse ever reaches the pins. A rate code outside the supported set parks the clocks low and raises an error flag.

The serial format is left-justified. Each frame clock is high for the left word and low for the right word. Words go MSB first: data changes after a falling bit-clock edge and is sampled on the rising edge. Bits after the last word bit read as zero.

Top module: `audio_port_clocking`

## Requirements
- R1: After reset the block is in slave mode. The clock-drive enable, all three clock outputs, the serial ADC data, the word-valid pulse and the error flag are all 0.
- R2: A write to address 0x07 sets master mode from data bit 6 (1 = master, 0 = slave). A write to address 0x08 sets the USB select from bit 0, the oversampling select from bit 1 and the rate code from bits 5:2. Writes to any other address change nothing.
- R3: In normal mode with a 48 kHz-class rate, one frame lasts 256 master clocks (oversampling select 0) or 384 (select 1). Rate code 7 halves these to 128 or 192, and an 8 kHz-class rate multiplies them by six. The frame clock is high for exactly half the frame.
- R4: In USB mode a 48 kHz-class frame lasts 250 master clocks (select 0) or 272 (select 1), with 8 kHz-class frames six times longer. The high time is half the frame rounded down to an even count (124 for 250).
- R5: Rate code 0 runs both paths at the 48 kHz class and code 3 runs both at the 8 kHz class. Code 1 gives ADC 48 kHz with DAC 8 kHz, and code 2 gives ADC 8 kHz with DAC 48 kHz.
- R6: Rate codes 4, 5, 6 and 8–15 are unsupported, and so is code 7 in USB mode. An unsupported code raises the error flag and holds all clock outputs low. Writing a supported code clears the flag and restarts the clocks.
- R7: While clocks run, a new rate takes effect only where the ADC and DAC frames both end. The frame in progress completes with the old length.
- R8: In master mode the bit clock toggles on every master clock, and frame clock edges coincide with bit clock falling edges.
- R9: ADC words are sent MSB first: the left word while the frame clock is high, the right word while it is low. The first bit is valid at the first rising bit clock edge after the frame edge, and bits after the 16th are zero.
- R10: The DAC line is sampled on the first 16 rising bit clock edges of each half-frame. When the 16th right bit is taken, both parallel words are updated and the valid output pulses for exactly one cycle.
- R11: In slave mode the clock-drive enable and all clock outputs stay 0. The ADC data and DAC capture follow the externally applied bit and frame clocks, which are re-timed through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register address |
| regData | input | 9 | Register write data |
| bclkIn | input | 1 | External bit clock (slave) |
| adcLrcIn | input | 1 | External ADC frame clock (slave) |
| dacLrcIn | input | 1 | External DAC frame clock (slave) |
| bclkOut | output | 1 | Generated bit clock (master) |
| adcLrcOut | output | 1 | Generated ADC frame clock |
| dacLrcOut | output | 1 | Generated DAC frame clock |
| clkOe | output | 1 | Drive enable for the three clock pins |
| adcData | output | 1 | Serial ADC data |
| dacData | input | 1 | Serial DAC data |
| adcLeftWord | input | 16 | Parallel left ADC sample |
| adcRightWord | input | 16 | Parallel right ADC sample |
| dacLeftWord | output | 16 | Captured left DAC sample |
| dacRightWord | output | 16 | Captured right DAC sample |
| dacValid | output | 1 | One-cycle pulse on a new DAC pair |
| rateError | output | 1 | Unsupported rate code active |

## Verification
A wrong frame counter or a wrong period decode shows up as a frame clock period or high time that is off by some master clocks. It can be seen within two frames of the setting taking effect. A config committed at the wrong point makes the frame in progress shorter or longer than the old length, so the period is measured across a mid-frame write. A fault in the shift or capture path corrupts the parallel or serial words within one frame. Slave re-timing faults appear as misaligned bits on the first externally clocked frame.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int CNT_W = 12;
  localparam int RATE_W = 4;

  typedef enum logic [1:0] {SPD_96, SPD_48, SPD_8, SPD_BAD} spd_e;

  typedef struct packed {
    logic              master;
    logic              usb;
    logic              bosr;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  typedef struct packed {
    logic bitRise;
    logic bitFall;
    logic adcLeft;
    logic adcRight;
    logic dacLeft;
    logic dacRight;
  } strobe_t;

  // Speed class of one path for a given setting
  function automatic spd_e speedOf(cfg_t c, logic dacSide);
    case (c.rate)
      4'd0: return SPD_48;
      4'd1: return dacSide ? SPD_8 : SPD_48;
      4'd2: return dacSide ? SPD_48 : SPD_8;
      4'd3: return SPD_8;
      4'd7: return c.usb ? SPD_BAD : SPD_96;
      default: return SPD_BAD;
    endcase
  endfunction

  function automatic logic isBad(cfg_t c);
    return (speedOf(c, 1'b0) == SPD_BAD) || (speedOf(c, 1'b1) == SPD_BAD);
  endfunction

  // Frame length in master clocks
  function automatic logic [CNT_W-1:0] periodOf(cfg_t c, spd_e s);
    int base;
    base = c.usb ? (c.bosr ? 272 : 250) : (c.bosr ? 384 : 256);
    case (s)
      SPD_96: base = base / 2;
      SPD_8:  base = base * 6;
      default: ;
    endcase
    return CNT_W'(base);
  endfunction

  // High time: half the frame, forced even so edges meet a bit clock fall
  function automatic logic [CNT_W-1:0] halfOf(logic [CNT_W-1:0] p);
    return {1'b0, p[CNT_W-1:2], 1'b0};
  endfunction
endpackage

// File: rtl/apc_clock_ctrl.sv
module apc_clock_ctrl
  import apc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h07,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 7'h08,
  parameter int MODE_BIT = 6,
  parameter int SYNC_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bclkIn,
  input  logic              adcLrcIn,
  input  logic              dacLrcIn,
  output strobe_t           strb,
  output logic              bclkOut,
  output logic              adcLrcOut,
  output logic              dacLrcOut,
  output logic              clkOe,
  output logic              rateError
);
  localparam int FIELD_W = RATE_W + 2;

  cfg_t pendCfg, actCfg, nextCfg;
  logic [CNT_W-1:0] adcCnt, dacCnt, adcCntN, dacCntN;
  logic [CNT_W-1:0] adcPer, dacPer, adcPerN, dacPerN, adcHalfN, dacHalfN;
  logic actRun, nextRun, wrapBoth, commit;
  logic adcLrcQ, dacLrcQ;
  logic [SYNC_N-1:0] bSync, aSync, dSync;
  strobe_t mStrb, sStrb;

  // Register write port: pending settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg <= '0;
    end else if (wrEn) begin
      if (wrAddr == MODE_ADDR)
        pendCfg.master <= wrData[MODE_BIT];
      else if (wrAddr == RATE_ADDR)
        {pendCfg.rate, pendCfg.bosr, pendCfg.usb} <= wrData[FIELD_W-1:0];
    end
  end

  assign actRun   = actCfg.master && !isBad(actCfg);
  assign adcPer   = periodOf(actCfg, speedOf(actCfg, 1'b0));
  assign dacPer   = periodOf(actCfg, speedOf(actCfg, 1'b1));
  assign wrapBoth = (adcCnt == adcPer - CNT_W'(1)) && (dacCnt == dacPer - CNT_W'(1));
  assign commit   = !actRun || wrapBoth;
  assign nextCfg  = commit ? pendCfg : actCfg;
  assign nextRun  = nextCfg.master && !isBad(nextCfg);
  assign adcPerN  = periodOf(nextCfg, speedOf(nextCfg, 1'b0));
  assign dacPerN  = periodOf(nextCfg, speedOf(nextCfg, 1'b1));
  assign adcHalfN = halfOf(adcPerN);
  assign dacHalfN = halfOf(dacPerN);

  always_comb begin
    if (!nextRun || commit || adcCnt == adcPer - CNT_W'(1)) adcCntN = '0;
    else adcCntN = adcCnt + CNT_W'(1);
    if (!nextRun || commit || dacCnt == dacPer - CNT_W'(1)) dacCntN = '0;
    else dacCntN = dacCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCfg  <= '0;
      adcCnt  <= '0;
      dacCnt  <= '0;
      adcLrcQ <= 1'b0;
      dacLrcQ <= 1'b0;
    end else begin
      actCfg  <= nextCfg;
      adcCnt  <= adcCntN;
      dacCnt  <= dacCntN;
      adcLrcQ <= nextRun && (adcCntN < adcHalfN);
      dacLrcQ <= nextRun && (dacCntN < dacHalfN);
    end
  end

  // Slave re-timing: two flops plus one for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      aSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_N-2:0], bclkIn};
      aSync <= {aSync[SYNC_N-2:0], adcLrcIn};
      dSync <= {dSync[SYNC_N-2:0], dacLrcIn};
    end
  end

  always_comb begin
    mStrb.bitFall  = actRun && adcCnt[0];
    mStrb.bitRise  = actRun && !adcCnt[0];
    mStrb.adcLeft  = nextRun && (adcCntN == '0);
    mStrb.adcRight = nextRun && (adcCntN == adcHalfN);
    mStrb.dacLeft  = nextRun && (dacCntN == '0);
    mStrb.dacRight = nextRun && (dacCntN == dacHalfN);
    sStrb.bitRise  = bSync[SYNC_N-2] && !bSync[SYNC_N-1];
    sStrb.bitFall  = !bSync[SYNC_N-2] && bSync[SYNC_N-1];
    sStrb.adcLeft  = aSync[SYNC_N-2] && !aSync[SYNC_N-1];
    sStrb.adcRight = !aSync[SYNC_N-2] && aSync[SYNC_N-1];
    sStrb.dacLeft  = dSync[SYNC_N-2] && !dSync[SYNC_N-1];
    sStrb.dacRight = !dSync[SYNC_N-2] && dSync[SYNC_N-1];
    strb = actCfg.master ? mStrb : sStrb;
  end

  assign bclkOut   = actRun && adcCnt[0];
  assign adcLrcOut = adcLrcQ;
  assign dacLrcOut = dacLrcQ;
  assign clkOe     = actCfg.master;
  assign rateError = isBad(actCfg);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    actRun |-> (adcCnt < adcPer) && (dacCnt < dacPer));
  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    rateError |-> (!bclkOut && !adcLrcOut && !dacLrcOut));
  assert_cfg_at_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    (actRun && $past(actRun) && actCfg != $past(actCfg)) |-> (adcCnt == '0 && dacCnt == '0));
  assert_bclk_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (actRun && $past(actRun)) |-> (bclkOut != $past(bclkOut)));
  assert_lrc_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (actRun && $past(actRun) && (adcLrcOut != $past(adcLrcOut) || dacLrcOut != $past(dacLrcOut)))
      |-> !bclkOut);
  assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !clkOe |-> (!bclkOut && !adcLrcOut && !dacLrcOut));
endmodule

// File: rtl/apc_serial_path.sv
module apc_serial_path
  import apc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] adcLeftWord,
  input  logic [WORD_W-1:0] adcRightWord,
  output logic              adcData,
  input  logic              dacData,
  output logic [WORD_W-1:0] dacLeftWord,
  output logic [WORD_W-1:0] dacRightWord,
  output logic              dacValid
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] IDLE_CNT = BIT_W'(WORD_W);

  logic [WORD_W-1:0] adcSh, dacSh, dacShN;
  logic [BIT_W-1:0]  bitCnt;
  logic              chanRight;

  // ADC: load at frame edge, shift on falling bit clock, zero fill
  always_ff @(posedge clk) begin
    if (!rstN) adcSh <= '0;
    else if (strb.adcLeft) adcSh <= adcLeftWord;
    else if (strb.adcRight) adcSh <= adcRightWord;
    else if (strb.bitFall) adcSh <= {adcSh[WORD_W-2:0], 1'b0};
  end
  assign adcData = adcSh[WORD_W-1];

  // DAC: sample on rising bit clock, first WORD_W bits of each half
  assign dacShN = {dacSh[WORD_W-2:0], dacData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacSh        <= '0;
      bitCnt       <= IDLE_CNT;
      chanRight    <= 1'b0;
      dacLeftWord  <= '0;
      dacRightWord <= '0;
      dacValid     <= 1'b0;
    end else begin
      dacValid <= 1'b0;
      if (strb.dacLeft) begin
        bitCnt    <= '0;
        chanRight <= 1'b0;
      end else if (strb.dacRight) begin
        bitCnt    <= '0;
        chanRight <= 1'b1;
      end else if (strb.bitRise && bitCnt < IDLE_CNT) begin
        dacSh  <= dacShN;
        bitCnt <= bitCnt + BIT_W'(1);
        if (bitCnt == LAST_BIT) begin
          if (chanRight) begin
            dacRightWord <= dacShN;
            dacValid     <= 1'b1;
          end else begin
            dacLeftWord <= dacShN;
          end
        end
      end
    end
  end

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);
  assert_bit_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= IDLE_CNT);
  assert_valid_stable_left_R10: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> $stable(dacLeftWord));
endmodule

// File: rtl/audio_port_clocking.sv
module audio_port_clocking
  import apc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              bclkIn,
  input  logic              adcLrcIn,
  input  logic              dacLrcIn,
  output logic              bclkOut,
  output logic              adcLrcOut,
  output logic              dacLrcOut,
  output logic              clkOe,
  output logic              adcData,
  input  logic              dacData,
  input  logic [WORD_W-1:0] adcLeftWord,
  input  logic [WORD_W-1:0] adcRightWord,
  output logic [WORD_W-1:0] dacLeftWord,
  output logic [WORD_W-1:0] dacRightWord,
  output logic              dacValid,
  output logic              rateError
);
  strobe_t strb;

  apc_clock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr), .wrData(regData),
    .bclkIn(bclkIn), .adcLrcIn(adcLrcIn), .dacLrcIn(dacLrcIn), .strb(strb),
    .bclkOut(bclkOut), .adcLrcOut(adcLrcOut), .dacLrcOut(dacLrcOut),
    .clkOe(clkOe), .rateError(rateError)
  );

  apc_serial_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .adcLeftWord(adcLeftWord), .adcRightWord(adcRightWord), .adcData(adcData),
    .dacData(dacData), .dacLeftWord(dacLeftWord), .dacRightWord(dacRightWord),
    .dacValid(dacValid)
  );
endmodule

// File: tb/audio_port_clocking_bench.sv
module audio_port_clocking_bench;
  localparam int W = 16;
  localparam int NV = 10;
  // usb, bosr, rate, adcPeriod, adcHigh, dacPeriod, dacHigh
  localparam int VEC [NV][7] = '{
    '{0, 0, 0,  256, 128,  256, 128},
    '{0, 1, 0,  384, 192,  384, 192},
    '{0, 0, 7,  128,  64,  128,  64},
    '{0, 1, 7,  192,  96,  192,  96},
    '{0, 0, 1,  256, 128, 1536, 768},
    '{0, 0, 2, 1536, 768,  256, 128},
    '{1, 0, 0,  250, 124,  250, 124},
    '{1, 1, 0,  272, 136,  272, 136},
    '{1, 1, 3, 1632, 816, 1632, 816},
    '{0, 1, 3, 2304, 1152, 2304, 1152}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, regWrEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [8:0] regData = '0;
  logic bclkIn = 1'b0, adcLrcIn = 1'b0, dacLrcIn = 1'b0, dacData = 1'b0;
  logic [W-1:0] adcLeftWord = '0, adcRightWord = '0;
  logic bclkOut, adcLrcOut, dacLrcOut, clkOe, adcData, dacValid, rateError;
  logic [W-1:0] dacLeftWord, dacRightWord;

  int checks = 0, errors = 0, validCnt = 0;
  logic [W-1:0] gotL = '0, gotR = '0;

  audio_port_clocking u_audio_port_clocking (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .bclkIn(bclkIn), .adcLrcIn(adcLrcIn), .dacLrcIn(dacLrcIn),
    .bclkOut(bclkOut), .adcLrcOut(adcLrcOut), .dacLrcOut(dacLrcOut), .clkOe(clkOe),
    .adcData(adcData), .dacData(dacData), .adcLeftWord(adcLeftWord),
    .adcRightWord(adcRightWord), .dacLeftWord(dacLeftWord), .dacRightWord(dacRightWord),
    .dacValid(dacValid), .rateError(rateError)
  );

  always @(negedge clk) begin
    if (dacValid) begin
      gotL <= dacLeftWord;
      gotR <= dacRightWord;
      validCnt <= validCnt + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [8:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic lrcOf(input bit dacSide);
    return dacSide ? dacLrcOut : adcLrcOut;
  endfunction

  task automatic waitRise(input bit dacSide);
    logic p, c;
    int n;
    p = lrcOf(dacSide);
    n = 0;
    while (n < 6000) begin
      @(negedge clk);
      c = lrcOf(dacSide);
      if (c && !p) break;
      p = c;
      n++;
    end
  endtask

  task automatic measure(input bit dacSide, output int per, output int high);
    logic p, c;
    waitRise(dacSide);
    per = 0; high = 1; p = 1'b1;
    while (per < 6000) begin
      @(negedge clk);
      c = lrcOf(dacSide);
      per++;
      if (c && !p) break;
      if (c) high++;
      p = c;
    end
  endtask

  task automatic masterData(input logic [W-1:0] dl, input logic [W-1:0] dr);
    logic pB, pL, b, l;
    logic [W-1:0] capL, capR, dWord;
    int idx, dIdx, half, zeroBad, n, v0;
    adcLeftWord = 16'hA5C3; adcRightWord = 16'h3C5A;
    capL = '0; capR = '0; zeroBad = 0;
    waitRise(1'b0);
    v0 = validCnt;
    dWord = dl; dacData = dl[W-1]; dIdx = 1; idx = 0; half = 0;
    pB = bclkOut; pL = adcLrcOut;
    for (n = 0; n < 600; n++) begin
      @(negedge clk);
      b = bclkOut; l = adcLrcOut;
      if (l && !pL) break;
      if (!l && pL) begin
        half = 1; idx = 0; dWord = dr; dacData = dr[W-1]; dIdx = 1;
      end else if (!b && pB) begin
        dacData = (dIdx < W) ? dWord[W-1-dIdx] : 1'b0;
        dIdx++;
      end
      if (b && !pB) begin
        if (idx < W) begin
          if (half == 0) capL[W-1-idx] = adcData; else capR[W-1-idx] = adcData;
        end else if (adcData != 1'b0) zeroBad++;
        idx++;
      end
      pB = b; pL = l;
    end
    repeat (4) @(negedge clk);
    check("R9", "adc left word", capL, 16'hA5C3);
    check("R9", "adc right word", capR, 16'h3C5A);
    check("R9", "bits after word nonzero", zeroBad, 0);
    check("R10", "dac valid pulses", validCnt - v0, 1);
    check("R10", "dac left word", gotL, dl);
    check("R10", "dac right word", gotR, dr);
  endtask

  task automatic slaveFrame(input logic [W-1:0] dl, input logic [W-1:0] dr);
    logic [W-1:0] capL, capR, dWord;
    int zeroBad, v0;
    capL = '0; capR = '0; zeroBad = 0; v0 = validCnt;
    adcLeftWord = 16'h1E2D; adcRightWord = 16'hC3B4;
    for (int h = 0; h < 2; h++) begin
      dWord = (h == 0) ? dl : dr;
      for (int b = 0; b < 20; b++) begin
        @(negedge clk);
        bclkIn = 1'b0;
        if (b == 0) begin adcLrcIn = (h == 0); dacLrcIn = (h == 0); end
        dacData = (b < W) ? dWord[W-1-b] : 1'b0;
        repeat (6) @(negedge clk);
        if (b < W) begin
          if (h == 0) capL[W-1-b] = adcData; else capR[W-1-b] = adcData;
        end else if (adcData != 1'b0) zeroBad++;
        bclkIn = 1'b1;
        repeat (5) @(negedge clk);
      end
    end
    @(negedge clk);
    bclkIn = 1'b0;
    repeat (10) @(negedge clk);
    check("R11", "slave adc left", capL, 16'h1E2D);
    check("R11", "slave adc right", capR, 16'hC3B4);
    check("R11", "slave zero fill", zeroBad, 0);
    check("R11", "slave dac valid pulses", validCnt - v0, 1);
    check("R11", "slave dac left", gotL, dl);
    check("R11", "slave dac right", gotR, dr);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int per, high, ones, tog, n;
    logic pb, pl;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "clkOe", clkOe, 0);
    check("R1", "bclkOut", bclkOut, 0);
    check("R1", "adcLrcOut", adcLrcOut, 0);
    check("R1", "adcData", adcData, 0);
    check("R1", "rateError", rateError, 0);
    check("R1", "dacValid", dacValid, 0);

    // R2: stray address ignored, then mode register selects master
    wrReg(7'h09, 9'h1FF);
    repeat (20) @(negedge clk);
    check("R2", "clkOe after write to other address", clkOe, 0);
    check("R2", "rateError after write to other address", rateError, 0);
    wrReg(7'h07, 9'h040);
    repeat (3) @(negedge clk);
    check("R2", "clkOe after mode write", clkOe, 1);

    // R8: bit clock toggles every master clock
    repeat (10) @(negedge clk);
    tog = 0; pb = bclkOut;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bclkOut != pb) tog++;
      pb = bclkOut;
    end
    check("R8", "bit clock toggles in 20 cycles", tog, 20);
    waitRise(1'b0);
    check("R8", "bclk low at frame edge", bclkOut, 0);

    // R3 R4 R5: table of rate settings
    for (int v = 0; v < NV; v++) begin
      wrReg(7'h08, 9'((VEC[v][2] << 2) | (VEC[v][1] << 1) | VEC[v][0]));
      repeat (2500) @(negedge clk);
      measure(1'b0, per, high);
      check("R3_R4_R5", $sformatf("vec %0d adc period", v), per, VEC[v][3]);
      check("R3_R4_R5", $sformatf("vec %0d adc high", v), high, VEC[v][4]);
      measure(1'b1, per, high);
      check("R3_R4_R5", $sformatf("vec %0d dac period", v), per, VEC[v][5]);
      check("R3_R4_R5", $sformatf("vec %0d dac high", v), high, VEC[v][6]);
    end

    // R7: mid-frame rate change waits for the frame boundary
    wrReg(7'h08, 9'h000);
    repeat (2500) @(negedge clk);
    waitRise(1'b0);
    n = 0; pl = 1'b1;
    while (n < 6000) begin
      @(negedge clk);
      n++;
      if (n == 50) begin regWrEn = 1'b1; regAddr = 7'h08; regData = 9'h00C; end
      if (n == 51) regWrEn = 1'b0;
      if (adcLrcOut && !pl) break;
      pl = adcLrcOut;
    end
    check("R7", "frame in progress keeps old length", n, 256);
    measure(1'b0, per, high);
    check("R7", "next frame uses new length", per, 1536);

    // R9 R10: master data path at 48 kHz class
    wrReg(7'h08, 9'h000);
    repeat (2000) @(negedge clk);
    masterData(16'h9F21, 16'h4E87);
    masterData(16'h0001, 16'h8000);

    // R6: unsupported codes stop clocks and raise the flag
    wrReg(7'h08, 9'h014);
    repeat (300) @(negedge clk);
    check("R6", "error flag for code 5", rateError, 1);
    ones = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclkOut || adcLrcOut || dacLrcOut) ones++;
    end
    check("R6", "clocks held low", ones, 0);
    wrReg(7'h08, 9'h01D);
    repeat (5) @(negedge clk);
    check("R6", "error flag for usb code 7", rateError, 1);
    wrReg(7'h08, 9'h000);
    repeat (3) @(negedge clk);
    check("R6", "error cleared", rateError, 0);
    measure(1'b0, per, high);
    check("R6", "clocks restart at 256", per, 256);

    // R11: slave mode
    wrReg(7'h07, 9'h000);
    repeat (400) @(negedge clk);
    check("R11", "clkOe in slave", clkOe, 0);
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclkOut || adcLrcOut || dacLrcOut) ones++;
    end
    check("R11", "clock outputs quiet in slave", ones, 0);
    slaveFrame(16'h7A5B, 16'hB6C1);
    slaveFrame(16'hFFFF, 16'h0F0F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule